// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block is the front end of a simple interrupt controller. Eight device request lines are gathered into a pending-request register. Devices raise bits through a post vector and drop them through a clear vector. Software drops a single bit by writing its index to an acknowledge port. A single level-sensitive interrupt line to the CPU is high whenever some pending bit is also enabled.

Software reaches the block through a small byte bus with a 3-bit address and a write strobe. The read data is combinational on the address. The primary mask port works in inverted sense: a 1 written to a bit disables that line, and a read returns the byte that was last written. A second controller is present only in stub form. Its status port always reads zero, and its mask port is a plain storage byte that has no effect on the interrupt.

Top module: `irqagg_top`

## Requirements
- R1: After reset the pending register is 0x00, every line is disabled (the primary mask reads 0xFF), the secondary mask reads 0xFF, and `irq_o` is low.
- R2: A write to the primary mask (address 0) stores the bitwise inverse of the data as the enable set. A later read of address 0 returns the written byte.
- R3: A read of the primary status port (address 1) returns the pending register.
- R4: A 1 on bit i of `post_vec_i` sets pending bit i at the next clock edge.
- R5: A 1 on bit i of `clr_vec_i` clears pending bit i at the next clock edge. When post and clear name the same bit in the same cycle, the bit ends up clear.
- R6: A write to the acknowledge port (address 2) clears the pending bit indexed by data bits [3:0]. Indices 8 to 15 change nothing.
- R7: `irq_o` is high exactly when (pending AND enable) is nonzero. It follows register changes from mask writes, acknowledges, posts and clears in the cycle after the clock edge that commits them.
- R8: The secondary status port (address 4) always reads 0x00. The secondary mask (address 3) stores and returns the written byte and never affects `irq_o`.
- R9: Addresses 5 to 7 read 0x00, and writes to them, or to a status port, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we_i | input | 1 | Write strobe for the byte bus |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on bus_addr_i |
| post_vec_i | input | 8 | Device request set vector |
| clr_vec_i | input | 8 | Device request clear vector |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The assertions assume that the post and clear vectors and the bus strobe are valid on every clock edge after reset. They make no assumption about values present while reset is held, because each history check is gated by reset having been released in the prior cycle. The stimulus changes all inputs only on falling edges and returns the strobes and vectors to zero after each one-cycle operation. This includes same-cycle post and clear on one bit, and acknowledge indices above seven.

// File: rtl/irqagg_pkg.sv
// Package: shared widths and register-select codes for the interrupt aggregator.
// Assumes a 3-bit byte-bus address space; codes 5..7 are unmapped.
package irqagg_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned IDX_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PMASK = 3'd0,
        SEL_PSTAT = 3'd1,
        SEL_PACK  = 3'd2,
        SEL_SMASK = 3'd3,
        SEL_SSTAT = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irqagg_pending.sv
// Module: pending-request register.
// Sets bits from the post vector and clears bits from the clear vector or an
// acknowledge index. Clearing wins over setting. Indices at or above WIDTH are
// ignored. Assumes inputs are synchronous to clk.
module irqagg_pending #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned IDXW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] post_vec,
    input  logic [WIDTH-1:0] clr_vec,
    input  logic             ack_we,
    input  logic [IDXW-1:0]  ack_idx,
    output logic [WIDTH-1:0] pend
);
    logic [WIDTH-1:0] ack_vec;
    logic [WIDTH-1:0] clr_all;

    // One-hot decode of the acknowledge index; out-of-range indices select nothing
    for (genvar i = 0; i < WIDTH; i++) begin : g_ack
        assign ack_vec[i] = ack_we && (ack_idx == IDXW'(i));
    end

    // Merge device clears and software acknowledge
    assign clr_all = clr_vec | ack_vec;

    // Pending register update: set, then clear takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | post_vec) & ~clr_all;
    end

    // R4
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ($past(post_vec) & ~$past(clr_all)))
                          == ($past(post_vec) & ~$past(clr_all))));
    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(clr_vec)) == '0));
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_idx < IDXW'(WIDTH)) |=> (pend[$past(ack_idx)] == 1'b0));
    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(post_vec)) == '0));
endmodule

// File: rtl/irqagg_maskreg.sv
// Module: one mask storage byte.
// With INVERT set it keeps the complement of the written data as an enable
// set; otherwise it keeps the data as is. Either way a read returns the last
// written byte. RST_VAL is the stored value after reset.
module irqagg_maskreg #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          INVERT  = 1'b1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] store,
    output logic [WIDTH-1:0] rd_val
);
    // Storage update, with optional inversion picked by the parameter
    if (INVERT) begin : g_inv
        always_ff @(posedge clk) begin
            if (!rst_n)  store <= RST_VAL;
            else if (we) store <= ~wdata;
        end
        assign rd_val = ~store;
    end else begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n)  store <= RST_VAL;
            else if (we) store <= wdata;
        end
        assign rd_val = store;
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rd_val == $past(wdata)));
endmodule

// File: rtl/irqagg_readmux.sv
// Module: byte-bus read selector. Purely combinational on the address.
// Unmapped codes and the secondary status port return zero.
module irqagg_readmux
    import irqagg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  pmask_rd,
    input  logic [WIDTH-1:0]  pend,
    input  logic [WIDTH-1:0]  smask_rd,
    output logic [WIDTH-1:0]  rdata
);
    // Select the read source by register code
    always_comb begin
        case (addr)
            SEL_PMASK: rdata = pmask_rd;
            SEL_PSTAT: rdata = pend;
            SEL_SMASK: rdata = smask_rd;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqagg_top.sv
// Module: masked interrupt request aggregator top.
// Decodes byte-bus writes, holds pending requests and the primary and
// secondary mask bytes, and drives one level interrupt from pending AND
// enable. Assumes a single-cycle write strobe and synchronous inputs.
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    output logic [LINES-1:0]  bus_rdata_o,
    input  logic [LINES-1:0]  post_vec_i,
    input  logic [LINES-1:0]  clr_vec_i,
    output logic              irq_o
);
    logic             wr_pmask, wr_smask, wr_ack;
    logic [LINES-1:0] pend, en_set, pmask_rd, smask_store, smask_rd;

    // Write decode per register code
    assign wr_pmask = bus_we_i && (bus_addr_i == SEL_PMASK);
    assign wr_smask = bus_we_i && (bus_addr_i == SEL_SMASK);
    assign wr_ack   = bus_we_i && (bus_addr_i == SEL_PACK);

    irqagg_pending #(.WIDTH(LINES), .IDXW(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .post_vec(post_vec_i), .clr_vec(clr_vec_i),
        .ack_we(wr_ack), .ack_idx(bus_wdata_i[IDX_W-1:0]),
        .pend(pend)
    );

    irqagg_maskreg #(.WIDTH(LINES), .INVERT(1'b1), .RST_VAL('0)) u_pmask (
        .clk(clk), .rst_n(rst_n), .we(wr_pmask), .wdata(bus_wdata_i),
        .store(en_set), .rd_val(pmask_rd)
    );

    irqagg_maskreg #(.WIDTH(LINES), .INVERT(1'b0), .RST_VAL('1)) u_smask (
        .clk(clk), .rst_n(rst_n), .we(wr_smask), .wdata(bus_wdata_i),
        .store(smask_store), .rd_val(smask_rd)
    );

    irqagg_readmux #(.WIDTH(LINES)) u_rmux (
        .addr(bus_addr_i), .pmask_rd(pmask_rd), .pend(pend),
        .smask_rd(smask_rd), .rdata(bus_rdata_o)
    );

    // Level interrupt from enabled pending requests
    assign irq_o = |(pend & en_set);

    // R7
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_addr_i != SEL_PMASK || bus_rdata_o != '1));
    // R7
    irq_from_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((post_vec_i & ~clr_vec_i & en_set) != '0) && !bus_we_i)
        |=> irq_o);
    // R8
    sstat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == SEL_SSTAT) |-> (bus_rdata_o == '0));
endmodule

// File: tb/irqagg_top_tb_top.sv
`timescale 1ns/1ps
module irqagg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] post_vec = 8'd0;
    logic [7:0] clr_vec = 8'd0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
        bit         is_irq;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    irqagg_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .post_vec_i(post_vec), .clr_vec_i(clr_vec), .irq_o(irq)
    );

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 8'd0;
    endtask

    task automatic dev(input logic [7:0] p, input logic [7:0] c);
        @(negedge clk);
        post_vec = p; clr_vec = c;
        @(negedge clk);
        post_vec = 8'd0; clr_vec = 8'd0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.tag = tag; it.exp = e; it.is_irq = 1'b0;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.tag = tag; it.exp = {7'd0, e}; it.is_irq = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            wait (sb_q.size() > 0);
            @(posedge clk);
            #2;
            it = sb_q.pop_front();
            act = it.is_irq ? {7'd0, irq} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_rd(3'd1, 8'h00, "R1 status after reset");
        exp_rd(3'd0, 8'hFF, "R1 pmask after reset");
        exp_rd(3'd3, 8'hFF, "R1 smask after reset");
        exp_irq(1'b0, "R1 irq after reset");

        dev(8'h05, 8'h00);
        exp_rd(3'd1, 8'h05, "R4 post sets bits / R3 status");
        exp_irq(1'b0, "R7 irq low while all disabled");

        bus_wr(3'd0, 8'hFE);
        exp_rd(3'd0, 8'hFE, "R2 pmask readback");
        exp_irq(1'b1, "R7 irq after enabling line 0");

        bus_wr(3'd2, 8'h00);
        exp_rd(3'd1, 8'h04, "R6 ack index 0");
        exp_irq(1'b0, "R7 irq drops after ack");

        bus_wr(3'd2, 8'h12);
        exp_rd(3'd1, 8'h00, "R6 ack uses low nibble only");

        dev(8'h80, 8'h00);
        bus_wr(3'd2, 8'h0F);
        exp_rd(3'd1, 8'h80, "R6 ack index 15 no effect");
        bus_wr(3'd2, 8'h08);
        exp_rd(3'd1, 8'h80, "R6 ack index 8 no effect");

        dev(8'h00, 8'h80);
        exp_rd(3'd1, 8'h00, "R5 clear input");
        dev(8'h30, 8'h10);
        exp_rd(3'd1, 8'h20, "R5 clear wins over post");

        bus_wr(3'd0, 8'hDF);
        exp_irq(1'b1, "R7 irq after enabling line 5");
        bus_wr(3'd0, 8'hFF);
        exp_irq(1'b0, "R7 irq after disabling all");
        exp_rd(3'd0, 8'hFF, "R2 pmask readback all ones");

        bus_wr(3'd3, 8'h00);
        exp_rd(3'd3, 8'h00, "R8 smask storage");
        exp_irq(1'b0, "R8 smask does not enable irq");
        exp_rd(3'd4, 8'h00, "R8 secondary status zero");

        bus_wr(3'd5, 8'hFF);
        exp_rd(3'd5, 8'h00, "R9 unmapped read zero");
        exp_rd(3'd1, 8'h20, "R9 unmapped write no effect");
        bus_wr(3'd1, 8'h00);
        exp_rd(3'd1, 8'h20, "R9 status write ignored");
        exp_rd(3'd7, 8'h00, "R9 address 7 reads zero");

        bus_wr(3'd0, 8'h00);
        exp_irq(1'b1, "R7 irq with all enabled");
        dev(8'h00, 8'h20);
        exp_irq(1'b0, "R7 irq after device clear");
        exp_rd(3'd1, 8'h00, "R5 status after device clear");

        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule